// File: doc/BRIEF.md
# Configurable-Role Serial Shift Port with Fault Flags

This block moves one byte at a time over a four-wire synchronous serial link, most significant bit first. A control input picks the role. As master, it generates the serial clock from a programmable divide of the system clock and drives the outgoing data line. As slave, it follows a serial clock and select line supplied from outside and drives the return data line only while selected. Two control inputs choose the clock's idle level and whether data is captured on the leading or the trailing edge. All four combinations are supported, and both ends of a link must use the same setting.

Software-side access is a byte write strobe and a read buffer. A write loads the transmit byte. As master, a write also starts a transfer. When the eighth bit is captured, the received byte appears on the read buffer and a completion flag is raised. Two error conditions are latched as flags. A mode fault occurs when the select line is seen low while the master role is requested. A write collision occurs when a byte is written while a transfer is in progress, in either role. A single clear input drops all three flags.

Top module: `spi_port`

## Requirements
- R1: As master, a write to idle loads the byte and starts an 8-bit transfer. The bits appear on `mosiOut` most significant first. At the end, `rdData` holds the 8 bits captured from `misoIn` and `doneFlag` is 1.
- R2: With `cpha`=0, the master presents a bit before the leading SCK edge, captures on the leading edge and changes data on the trailing edge. With `cpha`=1, data changes on the leading edge and is captured on the trailing edge. This holds for both values of `cpol`. A leading edge is one that leaves the idle level.
- R3: While the master is idle and not faulted, `sckOut` equals `cpol` and `sckOe` is 1.
- R4: Each SCK half period lasts `clkDiv` system clocks. A value of 0 is treated as 1, so a full SCK period is at least 2 system clocks.
- R5: As slave with `ssN` low, the port captures `mosiIn` on the capture edges and returns the previously written byte on `misoOut`, MSB first. With `cpha`=0, the first bit is presented when `ssN` falls. At the end, `rdData` holds the received byte and `doneFlag` is 1.
- R6: As slave with `ssN` high, SCK activity is ignored: `misoOe` stays 0, `doneFlag` stays 0 and `rdData` does not change.
- R7: If `ssN` is seen low while `masterEn` is 1, `modeFault` is set and `sckOe` and `mosiOe` go to 0. Any transfer in progress is abandoned without setting `doneFlag`.
- R8: As master, a write during a transfer sets `wrCollision`. The written byte is discarded and the ongoing transfer completes with the original byte.
- R9: As slave, a write while `ssN` is low sets `wrCollision`.
- R10: After reset, all three flags are 0, `rdData` is 0 and `sckOut` is at the `cpol` level. A `flagClr` pulse clears every flag that is not being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterEn | input | 1 | 1 selects the master role, 0 the slave role |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| clkDiv | input | 8 | SCK half period in system clocks (0 acts as 1) |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to transmit |
| rdData | output | 8 | Last received byte |
| flagClr | input | 1 | Clears all status flags |
| doneFlag | output | 1 | Transfer complete |
| modeFault | output | 1 | Select seen low in master role |
| wrCollision | output | 1 | Write during transfer |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock generated as master |
| sckOe | output | 1 | Drive enable for `sckOut` |
| mosiIn | input | 1 | Master-out data when acting as slave |
| mosiOut | output | 1 | Master-out data when acting as master |
| mosiOe | output | 1 | Drive enable for `mosiOut` |
| misoIn | input | 1 | Slave-out data when acting as master |
| misoOut | output | 1 | Slave-out data when acting as slave |
| misoOe | output | 1 | Drive enable for `misoOut` |
| ssN | input | 1 | Active-low slave select |

## Verification
The assertions assume the configuration inputs stay stable for the length of a transfer. This covers `masterEn`, `cpol`, `cpha` and `clkDiv`. If `clkDiv` shrank mid-transfer, the divider would overshoot its bound. If `masterEn` dropped mid-transfer, a slave load could coincide with a master transfer in flight. The bench changes these inputs only between transfers, after the SCK edge count or the wait time has run out. It drives the slave pins slowly, with an 8-clock half period, so the two-stage input synchroniser always settles before the opposite edge arrives.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
    logic commit;
  } spiStb_t;
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStb_t           stb,
  input  logic              masterEff,
  input  logic [DATA_W-1:0] wrData,
  input  logic              misoIn,
  input  logic              mosiSync,
  output logic              outBit,
  output logic [DATA_W-1:0] rdBuf
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;
  logic              inBit;

  // Receive source depends on role.
  assign inBit = masterEff ? misoIn : mosiSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      outBit <= 1'b0;
    end else if (stb.load && stb.drive) begin
      outBit <= wrData[MSB];
      txReg  <= {wrData[MSB-1:0], 1'b0};
    end else if (stb.load) begin
      txReg <= wrData;
    end else if (stb.drive) begin
      outBit <= txReg[MSB];
      txReg  <= {txReg[MSB-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      rdBuf <= '0;
    end else begin
      if (stb.sample) rxReg <= {rxReg[MSB-1:0], inBit};
      if (stb.commit) rdBuf <= {rxReg[MSB-1:0], inBit};
    end
  end

  // R8: transmit byte only moves on a load or drive strobe
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.drive) |=> $stable(txReg));

  // R1: received byte only changes on commit
  a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(rdBuf));
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterEn,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             wrEn,
  input  logic             flagClr,
  input  logic             sckIn,
  input  logic             ssN,
  input  logic             mosiIn,
  output spiStb_t          stb,
  output logic             masterEff,
  output logic             mosiSync,
  output logic             sckOut,
  output logic             misoOe,
  output logic             doneFlag,
  output logic             modeFault,
  output logic             wrCollision
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  logic [DIV_W-1:0]  halfPer, divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0]  slvCnt;
  logic              busy, sckTog;
  logic              ssS1, ssS2, ssPrev;
  logic              sckS1, sckS2, sckPrev;
  logic              mosiS1;
  logic              faultSet, slaveSel, mTick, mTickOk, mLead;
  logic              sEdge, sLead, start, slvLoad, collide, ssFall;
  logic              mSample, sSample, lastM, lastS;

  // Two-stage synchronisers for the external pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssS1 <= 1'b1; ssS2 <= 1'b1; ssPrev <= 1'b1;
      sckS1 <= 1'b0; sckS2 <= 1'b0; sckPrev <= 1'b0;
      mosiS1 <= 1'b0; mosiSync <= 1'b0;
    end else begin
      ssS1 <= ssN;    ssS2 <= ssS1;    ssPrev <= ssS2;
      sckS1 <= sckIn; sckS2 <= sckS1;  sckPrev <= sckS2;
      mosiS1 <= mosiIn; mosiSync <= mosiS1;
    end
  end

  always_comb begin
    halfPer   = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
    masterEff = masterEn && !modeFault;
    faultSet  = masterEn && !ssS2;
    slaveSel  = !masterEn && !ssS2;
    mTick     = busy && (divCnt == halfPer - DIV_W'(1));
    mTickOk   = mTick && !faultSet;
    mLead     = !edgeCnt[0];
    sEdge     = slaveSel && (sckS2 != sckPrev);
    sLead     = (sckPrev == cpol);
    start     = !busy && wrEn && masterEff && !faultSet;
    slvLoad   = wrEn && !masterEn && ssS2;
    collide   = wrEn && (busy || slaveSel);
    ssFall    = !masterEn && ssPrev && !ssS2;
    mSample   = mTickOk && (mLead != cpha);
    sSample   = sEdge && (sLead != cpha);
    lastM     = (edgeCnt[EDGE_W-1:1] == CNT_W'(DATA_W - 1));
    lastS     = (slvCnt == CNT_W'(DATA_W - 1));

    stb.load   = start || slvLoad;
    stb.drive  = (start && !cpha) || (mTickOk && (mLead == cpha)) ||
                 (sEdge && (sLead == cpha)) || (ssFall && !cpha);
    stb.sample = mSample || sSample;
    stb.commit = (mSample && lastM) || (sSample && lastS);
  end

  // Master clock generator and edge counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sckTog  <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (faultSet) begin
      busy   <= 1'b0;
      sckTog <= 1'b0;
      divCnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      sckTog  <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (busy) begin
      if (mTick) begin
        divCnt  <= '0;
        sckTog  <= ~sckTog;
        edgeCnt <= edgeCnt + EDGE_W'(1);
        if (edgeCnt == EDGE_W'(EDGES - 1)) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // Slave bit counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          slvCnt <= '0;
    else if (!slaveSel) slvCnt <= '0;
    else if (sSample)   slvCnt <= slvCnt + CNT_W'(1);
  end

  // Status flags: set wins over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag    <= 1'b0;
      modeFault   <= 1'b0;
      wrCollision <= 1'b0;
    end else begin
      if (stb.commit)   doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
      if (faultSet)     modeFault <= 1'b1;
      else if (flagClr) modeFault <= 1'b0;
      if (collide)      wrCollision <= 1'b1;
      else if (flagClr) wrCollision <= 1'b0;
    end
  end

  assign sckOut = cpol ^ sckTog;
  assign misoOe = slaveSel;

  // R7: a new fault leaves no master transfer running
  a_r7_fault_abort: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> !busy);

  // R4: divider stays inside the half period
  a_r4_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (divCnt < halfPer));

  // R3: idle master rests at the polarity level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && masterEff) |-> (sckOut == cpol));

  // R8: no load reaches the datapath while shifting
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.load);

  // R6: deselected slave never captures
  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn && ssS2) |-> !stb.sample);

  // R10: clear without a completing bit drops the done flag
  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !stb.commit) |=> !doneFlag);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              flagClr,
  output logic              doneFlag,
  output logic              modeFault,
  output logic              wrCollision,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  spiStb_t stb;
  logic    masterEff, mosiSync, outBit;

  spi_port_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .wrEn(wrEn), .flagClr(flagClr), .sckIn(sckIn),
    .ssN(ssN), .mosiIn(mosiIn), .stb(stb), .masterEff(masterEff),
    .mosiSync(mosiSync), .sckOut(sckOut), .misoOe(misoOe),
    .doneFlag(doneFlag), .modeFault(modeFault), .wrCollision(wrCollision)
  );

  spi_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .masterEff(masterEff),
    .wrData(wrData), .misoIn(misoIn), .mosiSync(mosiSync),
    .outBit(outBit), .rdBuf(rdData)
  );

  assign sckOe   = masterEff;
  assign mosiOe  = masterEff;
  assign mosiOut = outBit;
  assign misoOut = outBit;
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterEn = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] clkDiv = 8'd2;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       flagClr = 1'b0;
  logic       doneFlag, modeFault, wrCollision;
  logic       sckIn = 1'b0, sckOut, sckOe;
  logic       mosiIn = 1'b0, mosiOut, mosiOe;
  logic       misoIn, misoOut, misoOe;
  logic       ssN = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign misoIn = mosiOut;  // loopback for master runs

  spi_port dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .flagClr(flagClr), .doneFlag(doneFlag), .modeFault(modeFault),
    .wrCollision(wrCollision), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn),
    .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  // {cpol, cpha, clkDiv, byte}
  localparam logic [17:0] VEC [5] = '{
    {1'b0, 1'b0, 8'd2, 8'hA5},
    {1'b0, 1'b1, 8'd3, 8'h3C},
    {1'b1, 1'b0, 8'd1, 8'h81},
    {1'b1, 1'b1, 8'd4, 8'h7E},
    {1'b0, 1'b0, 8'd0, 8'hC3}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseClr();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk) begin wrEn = 1'b1; wrData = b; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic runMaster(input logic p, input logic h, input logic [7:0] d,
                           input logic [7:0] b);
    logic [7:0] cap;
    logic prev, lead;
    int edges, t, t1, t2, expHalf;
    masterEn = 1'b1; cpol = p; cpha = h; clkDiv = d;
    repeat (4) @(negedge clk);
    check(sckOut == p && sckOe, "R3 idle level", int'(sckOut), int'(p));
    pulseClr();
    writeByte(b);
    prev = sckOut; edges = 0; t = 0; t1 = 0; t2 = 0; cap = 8'h00;
    while (edges < 16 && t < 2000) begin
      @(negedge clk);
      t++;
      if (sckOut != prev) begin
        lead = (prev == p);
        if (lead ^ h) cap = {cap[6:0], mosiOut};
        edges++;
        if (edges == 1) t1 = t;
        if (edges == 2) t2 = t;
        prev = sckOut;
      end
    end
    repeat (3) @(negedge clk);
    expHalf = (d == 0) ? 1 : int'(d);
    check(t2 - t1 == expHalf, "R4 half period", t2 - t1, expHalf);
    check(cap == b, "R2 bits at capture edges", int'(cap), int'(b));
    check(rdData == b, "R1 received byte", int'(rdData), int'(b));
    check(doneFlag == 1'b1, "R1 done flag", int'(doneFlag), 1);
    check(sckOut == p, "R3 back to idle", int'(sckOut), int'(p));
  endtask

  task automatic runSlave(input logic p, input logic h, input logic [7:0] tx,
                          input logic [7:0] rx);
    logic [7:0] cap;
    masterEn = 1'b0; cpol = p; cpha = h; sckIn = p; ssN = 1'b1;
    repeat (6) @(negedge clk);
    pulseClr();
    writeByte(tx);
    repeat (4) @(negedge clk);
    ssN = 1'b0;
    repeat (8) @(negedge clk);
    cap = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (!h) begin
        mosiIn = rx[i];
        repeat (8) @(negedge clk);
        cap = {cap[6:0], misoOut};
        sckIn = ~p;
        repeat (8) @(negedge clk);
        sckIn = p;
      end else begin
        sckIn = ~p;
        mosiIn = rx[i];
        repeat (8) @(negedge clk);
        cap = {cap[6:0], misoOut};
        sckIn = p;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    check(misoOe == 1'b1, "R5 miso driven while selected", int'(misoOe), 1);
    ssN = 1'b1;
    repeat (6) @(negedge clk);
    check(cap == tx, "R5 slave returned byte", int'(cap), int'(tx));
    check(rdData == rx, "R5 slave received byte", int'(rdData), int'(rx));
    check(doneFlag == 1'b1, "R5 slave done", int'(doneFlag), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!doneFlag && !modeFault && !wrCollision, "R10 flags after reset",
          int'({doneFlag, modeFault, wrCollision}), 0);
    check(rdData == 8'h00, "R10 rdData after reset", int'(rdData), 0);
    check(sckOut == 1'b0, "R10 sckOut after reset", int'(sckOut), 0);

    // Vector table: master runs over all four modes and several dividers (R1 R2 R3 R4)
    for (int v = 0; v < 5; v++)
      runMaster(VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);

    // R8 master collision: second write discarded
    masterEn = 1'b1; cpol = 1'b0; cpha = 1'b0; clkDiv = 8'd4;
    repeat (4) @(negedge clk);
    pulseClr();
    writeByte(8'h3C);
    repeat (6) @(negedge clk);
    writeByte(8'hFF);
    check(wrCollision == 1'b1, "R8 collision flag", int'(wrCollision), 1);
    repeat (90) @(negedge clk);
    check(rdData == 8'h3C, "R8 original byte kept", int'(rdData), 8'h3C);
    check(doneFlag == 1'b1, "R8 transfer completed", int'(doneFlag), 1);

    // R10 clear
    pulseClr();
    check(!doneFlag && !wrCollision, "R10 flagClr", int'({doneFlag, wrCollision}), 0);

    // R7 mode fault mid-transfer
    writeByte(8'h5A);
    repeat (10) @(negedge clk);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    check(modeFault == 1'b1, "R7 fault flag", int'(modeFault), 1);
    check(!sckOe && !mosiOe, "R7 outputs released", int'({sckOe, mosiOe}), 0);
    repeat (100) @(negedge clk);
    check(doneFlag == 1'b0, "R7 transfer aborted", int'(doneFlag), 0);
    check(rdData == 8'h3C, "R7 rdData untouched", int'(rdData), 8'h3C);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    pulseClr();
    check(modeFault == 1'b0 && sckOe, "R7 recovery after clear",
          int'({modeFault, sckOe}), 1);

    // Slave runs (R5)
    runSlave(1'b0, 1'b0, 8'h96, 8'h4B);
    runSlave(1'b1, 1'b1, 8'hE1, 8'h2D);

    // R6 deselected slave ignores SCK
    masterEn = 1'b0; cpol = 1'b0; cpha = 1'b0; ssN = 1'b1; sckIn = 1'b0;
    repeat (4) @(negedge clk);
    pulseClr();
    held = rdData;
    for (int i = 0; i < 16; i++) begin
      mosiIn = ~mosiIn;
      sckIn = ~sckIn;
      repeat (6) @(negedge clk);
      if (i == 3) check(misoOe == 1'b0, "R6 miso not driven", int'(misoOe), 0);
    end
    repeat (6) @(negedge clk);
    check(doneFlag == 1'b0, "R6 no completion", int'(doneFlag), 0);
    check(rdData == held, "R6 rdData unchanged", int'(rdData), int'(held));

    // R9 slave collision while selected
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    writeByte(8'h11);
    check(wrCollision == 1'b1, "R9 slave collision", int'(wrCollision), 1);
    ssN = 1'b1;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule